// File: doc/BRIEF.md
# Priority-Driven Cache Configuration Tuner

This block picks a cache shape (capacity, ways, line length) for a newly seen program phase. Software or a phase classifier starts a tuning session with a one-cycle strobe. The block then tunes the instruction cache first and the data cache second, using the same state machine for both. Each cache begins from its own most-recently-used shape. The block applies one trial shape per phase execution and scores the execution when the phase-done strobe arrives. The score uses a metric chosen from the device state: energy-delay product, energy alone, or cycle count alone. While a new shape settles, the block holds a stall request for a fixed number of cycles.

The search grows capacity first, then ways, then line length, one power-of-two step at a time. A session for one cache ends on whichever of three events comes first: a trial strictly beats the best score seen so far, the shape is already at its maximum, or a fixed number of executions has been spent. The winning shape goes out on a one-cycle write port for the phase history table, tagged with the cache and the priority. It also becomes that cache's starting point for the next session. The power model and the cache datapath sit outside the block.

Top module: `cache_tuner`

## Requirements
- R1: A shape is coded as 7 bits {cap[6:4], way[3:2], line[1:0]}: capacity 2<<cap KB (cap 0..4), ways 1<<way (way 0..2), line 16<<line bytes (line 0..2). After reset both applied shapes equal the base shape, which by default is code {4,2,2}. A phase-done strobe while no session runs has no effect.
- R2: The device state is latched when a session starts: code 1 selects energy, code 2 selects cycles, and codes 0 and 3 select energy times cycles, using the full double-width product. wr_prio reports the latched metric as 0 (product), 1 (energy) or 2 (cycles). A later change of the device state does not affect the running session.
- R3: After a scored execution that does not end the search, the next trial raises cap by one if cap < 4. Otherwise it raises way if way < 2. Otherwise it raises line.
- R4: The search for a cache ends when a trial's score is strictly lower than the best score seen earlier in the same search. A tie does not end it.
- R5: The search ends after scoring a trial whose shape is {4,2,2}.
- R6: The search ends after N_EXEC scored executions (default 3).
- R7: When a search ends, wr_valid pulses for one cycle. It carries wr_cfg equal to the lowest-scoring trial (the earliest one on a tie), wr_sel (0 instruction, 1 data) and wr_prio. That shape is then applied to the cache and becomes its starting trial in the next session.
- R8: Every change of an applied shape raises stall_req in the same cycle and holds it for exactly STALL_CYC cycles (default 258). The first trial of a search is the shape already applied, so it causes no stall.
- R9: A phase-done strobe during a stall is ignored. The applied shape stays stable while the stall is held.
- R10: An applied shape never has more ways than its capacity has banks: way <= cap.
- R11: The instruction cache is tuned before the data cache. tune_done pulses for one cycle once both searches are done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_state | input | 2 | Device condition selecting the scoring metric |
| tune_start | input | 1 | One-cycle strobe starting a session (ignored while busy) |
| phase_done | input | 1 | One-cycle strobe: a phase execution finished |
| energy_i | input | EW | Energy of the finished execution |
| cycles_i | input | CW | Cycle count of the finished execution |
| i_cfg | output | 7 | Shape applied to the instruction cache |
| d_cfg | output | 7 | Shape applied to the data cache |
| stall_req | output | 1 | Reconfiguration stall request |
| wr_valid | output | 1 | History write strobe |
| wr_sel | output | 1 | History write target cache |
| wr_prio | output | 2 | History write priority |
| wr_cfg | output | 7 | History write shape |
| tune_done | output | 1 | Session finished strobe |

## Verification
Two events can fall in the same cycle: a phase-done strobe and an active reconfiguration stall. To provoke this, the bench injects a strobe with unrelated energy and cycle values partway through every stall. It then judges three things: the stall still lasts exactly STALL_CYC cycles, the applied shape does not move, and the next genuine execution is scored as if the injected strobe never happened. A second coincidence is the end of a search together with a final reconfiguration. Here the bench checks that the history write and the rising stall arrive in the same cycle, but only when the winner differs from the last trial. The sweep covers every metric against every score pattern, and the stored shapes climb until they reach the maximum.

// File: rtl/tuner_pkg.sv
package tuner_pkg;

    typedef struct packed {
        logic [2:0] cap;
        logic [1:0] way;
        logic [1:0] line;
    } cfg_t;

    localparam logic [2:0] CAP_TOP  = 3'd4;
    localparam logic [1:0] WAY_TOP  = 2'd2;
    localparam logic [1:0] LINE_TOP = 2'd2;

    typedef enum logic [1:0] {
        MET_EDP    = 2'd0,
        MET_ENERGY = 2'd1,
        MET_TIME   = 2'd2
    } metric_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RUN,
        ST_STALL,
        ST_NEXT
    } state_e;

    function automatic metric_e metric_of(input logic [1:0] dev);
        case (dev)
            2'd1:    return MET_ENERGY;
            2'd2:    return MET_TIME;
            default: return MET_EDP;
        endcase
    endfunction

    function automatic cfg_t legalize(input cfg_t c);
        cfg_t r;
        r.cap  = (c.cap  > CAP_TOP)  ? CAP_TOP  : c.cap;
        r.line = (c.line > LINE_TOP) ? LINE_TOP : c.line;
        r.way  = (c.way  > WAY_TOP)  ? WAY_TOP  : c.way;
        if ({1'b0, r.way} > r.cap) r.way = r.cap[1:0];
        return r;
    endfunction

endpackage

// File: rtl/tuner_step.sv
module tuner_step
    import tuner_pkg::*;
(
    input  cfg_t cur,
    output cfg_t nxt,
    output logic at_top
);
    always_comb begin
        nxt    = cur;
        at_top = 1'b0;
        if (cur.cap < CAP_TOP) begin
            nxt.cap = cur.cap + 3'd1;
        end else if (cur.way < WAY_TOP) begin
            nxt.way = cur.way + 2'd1;
        end else if (cur.line < LINE_TOP) begin
            nxt.line = cur.line + 2'd1;
        end else begin
            at_top = 1'b1;
        end
        nxt = legalize(nxt);
    end
endmodule

// File: rtl/tuner_score.sv
module tuner_score
    import tuner_pkg::*;
#(
    parameter int unsigned EW = 16,
    parameter int unsigned CW = 16,
    localparam int unsigned SW = EW + CW
) (
    input  metric_e         metric,
    input  logic [EW-1:0]   energy,
    input  logic [CW-1:0]   cycles,
    output logic [SW-1:0]   score
);
    always_comb begin
        case (metric)
            MET_ENERGY: score = SW'(energy);
            MET_TIME:   score = SW'(cycles);
            default:    score = SW'(energy) * SW'(cycles);
        endcase
    end
endmodule

// File: rtl/tuner_stall.sv
module tuner_stall #(
    parameter int unsigned CYC = 258,
    localparam int unsigned W = $clog2(CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy,
    output logic last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= W'(CYC);
        else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
    end

    assign busy = (cnt_q != '0);
    assign last = (cnt_q == W'(1));
endmodule

// File: rtl/cache_tuner.sv
module cache_tuner
    import tuner_pkg::*;
#(
    parameter int unsigned EW        = 16,
    parameter int unsigned CW        = 16,
    parameter int unsigned N_EXEC    = 3,
    parameter int unsigned STALL_CYC = 258,
    parameter int unsigned BASE_CAP  = 4,
    parameter int unsigned BASE_WAY  = 2,
    parameter int unsigned BASE_LINE = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    dev_state,
    input  logic          tune_start,
    input  logic          phase_done,
    input  logic [EW-1:0] energy_i,
    input  logic [CW-1:0] cycles_i,
    output logic [6:0]    i_cfg,
    output logic [6:0]    d_cfg,
    output logic          stall_req,
    output logic          wr_valid,
    output logic          wr_sel,
    output logic [1:0]    wr_prio,
    output logic [6:0]    wr_cfg,
    output logic          tune_done
);
    localparam int unsigned SW  = EW + CW;
    localparam int unsigned EXW = $clog2(N_EXEC + 1);
    localparam cfg_t BASE_CFG = legalize(cfg_t'({3'(BASE_CAP), 2'(BASE_WAY), 2'(BASE_LINE)}));

    state_e          st_q;
    metric_e         metric_q;
    logic            sel_q, have_q, final_q;
    logic [EXW-1:0]  exec_q;
    logic [SW-1:0]   best_q;
    cfg_t            best_cfg_q, trial_q;
    cfg_t            mru_q [2];
    cfg_t            app_q [2];

    cfg_t            step_cfg, win_cfg;
    logic            at_top, better, improved, stop, accept;
    logic            stall_load, stall_last;
    logic [SW-1:0]   score;
    logic [EXW-1:0]  exec_nx;

    tuner_step u_step (.cur(trial_q), .nxt(step_cfg), .at_top(at_top));

    tuner_score #(.EW(EW), .CW(CW)) u_score (
        .metric(metric_q), .energy(energy_i), .cycles(cycles_i), .score(score)
    );

    tuner_stall #(.CYC(STALL_CYC)) u_stall (
        .clk(clk), .rst(rst), .load(stall_load), .busy(stall_req), .last(stall_last)
    );

    always_comb begin
        accept     = (st_q == ST_RUN) && phase_done;
        improved   = have_q && (score < best_q);
        better     = !have_q || (score < best_q);
        exec_nx    = exec_q + EXW'(1);
        stop       = improved || at_top || (exec_nx == EXW'(N_EXEC));
        win_cfg    = better ? trial_q : best_cfg_q;
        stall_load = accept && (!stop || (win_cfg != trial_q));
    end

    always_ff @(posedge clk) begin
        wr_valid  <= 1'b0;
        tune_done <= 1'b0;
        if (rst) begin
            st_q       <= ST_IDLE;
            metric_q   <= MET_EDP;
            sel_q      <= 1'b0;
            have_q     <= 1'b0;
            final_q    <= 1'b0;
            exec_q     <= '0;
            best_q     <= '0;
            best_cfg_q <= BASE_CFG;
            trial_q    <= BASE_CFG;
            mru_q[0]   <= BASE_CFG;
            mru_q[1]   <= BASE_CFG;
            app_q[0]   <= BASE_CFG;
            app_q[1]   <= BASE_CFG;
            wr_sel     <= 1'b0;
            wr_prio    <= 2'd0;
            wr_cfg     <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (tune_start) begin
                    metric_q <= metric_of(dev_state);
                    sel_q    <= 1'b0;
                    st_q     <= ST_SETUP;
                end
                ST_SETUP: begin
                    trial_q <= mru_q[sel_q];
                    have_q  <= 1'b0;
                    exec_q  <= '0;
                    st_q    <= ST_RUN;
                end
                ST_RUN: if (accept) begin
                    exec_q <= exec_nx;
                    if (better) begin
                        best_q     <= score;
                        best_cfg_q <= trial_q;
                        have_q     <= 1'b1;
                    end
                    if (stop) begin
                        wr_valid      <= 1'b1;
                        wr_sel        <= sel_q;
                        wr_prio       <= metric_q;
                        wr_cfg        <= win_cfg;
                        mru_q[sel_q]  <= win_cfg;
                        app_q[sel_q]  <= win_cfg;
                        final_q       <= 1'b1;
                        st_q          <= (win_cfg != trial_q) ? ST_STALL : ST_NEXT;
                    end else begin
                        trial_q       <= step_cfg;
                        app_q[sel_q]  <= step_cfg;
                        final_q       <= 1'b0;
                        st_q          <= ST_STALL;
                    end
                end
                ST_STALL: if (stall_last) st_q <= final_q ? ST_NEXT : ST_RUN;
                ST_NEXT: begin
                    if (!sel_q) begin
                        sel_q <= 1'b1;
                        st_q  <= ST_SETUP;
                    end else begin
                        tune_done <= 1'b1;
                        st_q      <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign i_cfg = app_q[0];
    assign d_cfg = app_q[1];
endmodule

// File: rtl/tuner_chk.sv
module tuner_chk #(
    parameter int unsigned STALL_CYC = 258
) (
    input logic       clk,
    input logic       rst,
    input logic [6:0] i_cfg,
    input logic [6:0] d_cfg,
    input logic       stall_req,
    input logic       wr_valid,
    input logic       tune_done
);
    int unsigned run_q;

    always_ff @(posedge clk) begin
        if (rst)            run_q <= 0;
        else if (stall_req) run_q <= run_q + 1;
        else                run_q <= 0;
    end

    // R8: a stall run never exceeds its length
    a_r8_stall_len: assert property (@(posedge clk) disable iff (rst)
        run_q <= STALL_CYC);

    // R8: a finished stall run lasted exactly its length
    a_r8_stall_exact: assert property (@(posedge clk) disable iff (rst)
        (!stall_req && run_q != 0) |-> (run_q == STALL_CYC));

    // R8: any shape change comes with a stall
    a_r8_change_stalls: assert property (@(posedge clk) disable iff (rst)
        (!$stable(i_cfg) || !$stable(d_cfg)) |-> stall_req);

    // R9: shapes hold while the stall continues
    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (stall_req && $past(stall_req)) |-> ($stable(i_cfg) && $stable(d_cfg)));

    // R10: ways fit the bank count, fields in range
    a_r10_i_legal: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, i_cfg[3:2]} <= i_cfg[6:4]) && (i_cfg[6:4] <= 3'd4) && (i_cfg[1:0] <= 2'd2));
    a_r10_d_legal: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, d_cfg[3:2]} <= d_cfg[6:4]) && (d_cfg[6:4] <= 3'd4) && (d_cfg[1:0] <= 2'd2));

    // R7: history write is a single-cycle strobe
    a_r7_wr_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    // R11: done is a single-cycle strobe
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        tune_done |=> !tune_done);
endmodule

bind cache_tuner tuner_chk #(.STALL_CYC(STALL_CYC)) u_tuner_chk (
    .clk(clk), .rst(rst), .i_cfg(i_cfg), .d_cfg(d_cfg),
    .stall_req(stall_req), .wr_valid(wr_valid), .tune_done(tune_done)
);

// File: tb/tb_cache_tuner.sv
module tb_cache_tuner;
    localparam int CLK_PERIOD = 10;
    localparam int STALL_N    = 6;
    localparam int NEXEC      = 3;
    localparam int MAXCFG     = (4 << 4) | (2 << 2) | 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  dev_state = 2'd0;
    logic        tune_start = 1'b0;
    logic        phase_done = 1'b0;
    logic [15:0] energy_i = '0;
    logic [15:0] cycles_i = '0;
    logic [6:0]  i_cfg, d_cfg, wr_cfg;
    logic        stall_req, wr_valid, wr_sel, tune_done;
    logic [1:0]  wr_prio;

    int total = 0;
    int bad   = 0;
    bit finished = 0;
    int mru [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_tuner #(
        .EW(16), .CW(16), .N_EXEC(NEXEC), .STALL_CYC(STALL_N),
        .BASE_CAP(0), .BASE_WAY(0), .BASE_LINE(0)
    ) dut (
        .clk(clk), .rst(rst), .dev_state(dev_state), .tune_start(tune_start),
        .phase_done(phase_done), .energy_i(energy_i), .cycles_i(cycles_i),
        .i_cfg(i_cfg), .d_cfg(d_cfg), .stall_req(stall_req), .wr_valid(wr_valid),
        .wr_sel(wr_sel), .wr_prio(wr_prio), .wr_cfg(wr_cfg), .tune_done(tune_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int mode_of(input int dev);
        return (dev == 1) ? 1 : (dev == 2) ? 2 : 0;
    endfunction

    function automatic longint score_of(input int mode, input int e, input int c);
        if (mode == 1) return longint'(e);
        if (mode == 2) return longint'(c);
        return longint'(e) * longint'(c);
    endfunction

    function automatic int step_of(input int cfg);
        int cp = cfg >> 4;
        int wy = (cfg >> 2) & 3;
        int ln = cfg & 3;
        if (cp < 4)      cp++;
        else if (wy < 2) wy++;
        else if (ln < 2) ln++;
        return (cp << 4) | (wy << 2) | ln;
    endfunction

    function automatic int cur_cfg(input int c);
        return (c == 0) ? int'(i_cfg) : int'(d_cfg);
    endfunction

    // count the stall run already high at this negedge; inject a strobe inside it
    task automatic count_stall(input int c, input int exp_cfg);
        int cnt = 1;
        while (1) begin
            @(negedge clk);
            phase_done = 1'b0;
            if (!stall_req) break;
            cnt++;
            if (cnt == 2) begin
                phase_done = 1'b1;
                energy_i   = 16'd1;
                cycles_i   = 16'd1;
            end
        end
        chk(cnt == STALL_N, "R8 stall length", cnt, STALL_N);
        chk(cur_cfg(c) == exp_cfg, "R9 shape held across injected strobe", cur_cfg(c), exp_cfg);
    endtask

    task automatic wait_run();
        int lows = 0;
        while (lows < 4) begin
            @(negedge clk);
            if (stall_req) lows = 0; else lows++;
        end
    endtask

    task automatic gen(input int p, input int s, input int c, input int k,
                       output int e, output int cy);
        case (p)
            0: begin e = 300 - 40*k; cy = 100 + 30*k; end
            1: begin e = 200 + 20*k; cy = 400 - 100*k; end
            2: begin e = 150;        cy = 150;        end
            default: begin
                e  = ((s*7 + k*13 + c*3) % 50) + 100;
                cy = ((s*11 + k*5 + c*17) % 60) + 100;
            end
        endcase
    endtask

    task automatic session(input int s);
        int dev  = (s / 4) % 4;
        int p    = s % 4;
        int mode = mode_of(dev);
        @(negedge clk);
        tune_start = 1'b1;
        dev_state  = 2'(dev);
        @(negedge clk);
        tune_start = 1'b0;
        dev_state  = 2'((dev + 1) % 4);   // R2: must not affect this session
        for (int c = 0; c < 2; c++) begin
            int trial = mru[c];
            int bcfg  = trial;
            longint best = 0;
            bit have = 0;
            int k = 0;
            bit fin = 0;
            while (!fin) begin
                int e, cy, nxt;
                longint sc;
                bit improved, better, atmax, stop;
                string why;
                gen(p, s, c, k, e, cy);
                sc       = score_of(mode, e, cy);
                improved = have && (sc < best);
                better   = !have || (sc < best);
                if (better) begin best = sc; bcfg = trial; have = 1; end
                k++;
                atmax = (trial == MAXCFG);
                stop  = improved || atmax || (k == NEXEC);
                nxt   = step_of(trial);
                why   = improved ? "R4" : atmax ? "R5" : "R6";
                wait_run();
                phase_done = 1'b1;
                energy_i   = 16'(e);
                cycles_i   = 16'(cy);
                @(negedge clk);
                phase_done = 1'b0;
                if (!stop) begin
                    chk(wr_valid == 1'b0, "R4 no early stop", int'(wr_valid), 0);
                    chk(cur_cfg(c) == nxt, "R3 next trial order", cur_cfg(c), nxt);
                    chk(stall_req == 1'b1, "R8 stall on change", int'(stall_req), 1);
                    count_stall(c, nxt);
                    trial = nxt;
                end else begin
                    chk(wr_valid == 1'b1, {why, " search end strobe"}, int'(wr_valid), 1);
                    chk(int'(wr_cfg) == bcfg, {why, " R7 winner shape"}, int'(wr_cfg), bcfg);
                    chk(int'(wr_sel) == c, "R11 cache order", int'(wr_sel), c);
                    chk(int'(wr_prio) == mode, "R2 latched metric", int'(wr_prio), mode);
                    chk(cur_cfg(c) == bcfg, "R7 winner applied", cur_cfg(c), bcfg);
                    chk(stall_req == (bcfg != trial), "R8 final stall only on change",
                        int'(stall_req), int'(bcfg != trial));
                    if (stall_req) count_stall(c, bcfg);
                    mru[c] = bcfg;
                    fin = 1;
                end
            end
        end
        begin
            bit seen = 0;
            for (int w = 0; w < STALL_N + 10 && !seen; w++) begin
                if (tune_done) seen = 1;
                else @(negedge clk);
            end
            chk(seen, "R11 done after both caches", int'(seen), 1);
        end
    endtask

    initial begin
        mru[0] = 0;
        mru[1] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(i_cfg == 7'd0, "R1 reset shape icache", int'(i_cfg), 0);
        chk(d_cfg == 7'd0, "R1 reset shape dcache", int'(d_cfg), 0);
        chk(stall_req == 1'b0, "R8 no stall after reset", int'(stall_req), 0);
        // R1: strobe while idle has no effect
        phase_done = 1'b1;
        energy_i   = 16'd5;
        cycles_i   = 16'd5;
        @(negedge clk);
        phase_done = 1'b0;
        repeat (2) @(negedge clk);
        chk(wr_valid == 1'b0, "R1 idle strobe ignored (write)", int'(wr_valid), 0);
        chk(stall_req == 1'b0, "R1 idle strobe ignored (stall)", int'(stall_req), 0);
        chk(i_cfg == 7'd0, "R1 idle strobe ignored (shape)", int'(i_cfg), 0);
        for (int s = 0; s < 24; s++) session(s);
        chk(int'(i_cfg) == mru[0], "R10 final icache shape", int'(i_cfg), mru[0]);
        chk(int'(d_cfg) == mru[1], "R10 final dcache shape", int'(d_cfg), mru[1]);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule